// File: doc/BRIEF.md
# NAND Page Program and Block Erase Engine

This block runs the two write-side operations of a NAND array model: programming one page and erasing one block. The array is held in internal storage. It is organised as pages of `PAGE_BYTES` data bytes. Each page also carries a spare area of `PAGE_BYTES/32` bytes. Before a program, a host issues a setup strobe and then streams bytes over an 8-bit data bus into a page buffer. A program strobe then merges the buffer into the addressed page, one byte per clock. Because NAND cells can only lose charge, the merge is a bitwise AND with the existing contents. An erase strobe drives every byte of the block holding the addressed row back to 0xFF.

The write-protect input gates both operations, and so does a range check on the row address. A dropped operation leaves the array untouched but still answers with a done pulse. A column preset register adds an offset to the programmed column. It returns to zero once a program has been carried out. A registered read port exposes any array byte so that an outer read path, or a bench, can observe the cells.

Top module: `nand_pe_engine`

## Requirements
- R1: After reset, busy, prog_done and erase_done are low, and every array byte reads 0xFF.
- R2: A buffer byte is accepted on a clock where wr_en is high, cle and ale are both low and busy is low. After PAGE_BYTES+PAGE_BYTES/32 bytes have been accepted, further bytes are ignored.
- R3: A setup strobe taken while idle empties the buffer, so a program issued right after it writes nothing.
- R4: A program writes buffered byte i to column col_addr+preset+i of page row_addr, and the new value is old AND byte. A byte whose column falls at or past the end of the page (data plus spare) is discarded.
- R5: Once a program has been carried out, the column preset is zero; a later program lands at col_addr alone.
- R6: An erase sets to 0xFF every byte, spare included, of the 2^BLK_SHIFT pages starting at row_addr rounded down to a multiple of 2^BLK_SHIFT. It leaves all other pages unchanged.
- R7: With wp_n low, a program or erase strobe changes no cell, keeps busy low, and gives its done pulse in the following cycle.
- R8: A program or erase whose row_addr is NUM_PAGES or more changes no cell, keeps busy low, and gives its done pulse in the following cycle.
- R9: For an accepted operation, busy rises in the cycle after the strobe. It stays high for exactly the buffered byte count (program) or 2^BLK_SHIFT*(PAGE_BYTES+PAGE_BYTES/32) cycles (erase). In the cycle busy falls, a single one-cycle done pulse appears on the matching output.
- R10: Strobes issued while busy are ignored. When prog_go and erase_go arrive together, only the program runs.
- R11: rd_data shows the array byte at (rd_page, rd_col) one clock after that address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cle | input | 1 | Command phase line; blocks buffer fill when high |
| ale | input | 1 | Address phase line; blocks buffer fill when high |
| wr_en | input | 1 | Data-bus write strobe |
| din | input | 8 | Data byte for the page buffer |
| setup | input | 1 | Program setup: empties the page buffer |
| preset_wr | input | 1 | Loads the column preset while idle |
| preset_col | input | COL_W | Column preset value |
| col_addr | input | COL_W | Starting column of a program |
| row_addr | input | ROW_W | Page address of a program or erase |
| prog_go | input | 1 | Program confirm strobe |
| erase_go | input | 1 | Erase confirm strobe |
| wp_n | input | 1 | Write protect, active low |
| rd_page | input | PG_W | Read port page |
| rd_col | input | COL_W | Read port column |
| rd_data | output | 8 | Registered read data |
| busy | output | 1 | Operation in progress |
| prog_done | output | 1 | One-cycle end-of-program pulse |
| erase_done | output | 1 | One-cycle end-of-erase pulse |

## Verification
The bench builds the engine with 64-byte pages (a 2-byte spare, 66 bytes a page), 8 pages and 2-page-shift blocks of 4 pages. With these values an erase takes 264 cycles, a full-buffer program 66 cycles, and the whole array can be compared byte by byte against a model. Row values 9 and 12 fit in the 4-bit row port while lying past the array, so the range drop is reachable. A preset of 60 pushes a ten-byte program across the page end, so the clipping there is exercised. Erasing row 2 must clear pages 0 to 3 and leave pages 4 to 7 alone, which checks the block alignment from both sides.

// File: rtl/nand_pe_pkg.sv
package nand_pe_pkg;

  typedef enum logic [1:0] {
    PE_IDLE  = 2'd0,
    PE_PROG  = 2'd1,
    PE_ERASE = 2'd2
  } pe_state_e;

  // spare area is one thirty-second of the data area
  function automatic int spare_bytes(input int page_bytes);
    return page_bytes / 32;
  endfunction

  // first page of the block that holds a row
  function automatic int block_base(input int row, input int blk_shift);
    return (row >> blk_shift) << blk_shift;
  endfunction

  // column that buffered byte idx lands on
  function automatic int target_col(input int base, input int idx);
    return base + idx;
  endfunction

  // flat cell index of (page, col)
  function automatic int cell_index(input int page, input int col, input int page_total);
    return page * page_total + col;
  endfunction

  // NAND update rule: erase sets all ones, program only clears bits
  function automatic logic [7:0] merge_cell(input logic [7:0] old_v, input logic [7:0] new_v,
                                            input logic erase);
    return erase ? 8'hFF : (old_v & new_v);
  endfunction

endpackage

// File: rtl/pe_page_buffer.sv
module pe_page_buffer #(
  parameter int PAGE_TOTAL = 66,
  parameter int COL_W      = 7,
  parameter int CNT_W      = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr,
  input  logic [7:0]       din,
  input  logic [CNT_W-1:0] rd_idx,
  output logic [7:0]       rd_byte,
  output logic [CNT_W-1:0] fill_cnt
);

  logic [7:0] slots [PAGE_TOTAL];
  logic       room;
  logic       take;

  assign room = fill_cnt < CNT_W'(PAGE_TOTAL);
  assign take = wr && !clr && room;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    fill_cnt <= '0;
    else if (clr)  fill_cnt <= '0;
    else if (take) fill_cnt <= fill_cnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (take) slots[fill_cnt[COL_W-1:0]] <= din;
  end

  assign rd_byte = (rd_idx < CNT_W'(PAGE_TOTAL)) ? slots[rd_idx[COL_W-1:0]] : 8'hFF;

endmodule

// File: rtl/pe_cell_array.sv
module pe_cell_array
  import nand_pe_pkg::*;
#(
  parameter int NUM_PAGES  = 32,
  parameter int PAGE_TOTAL = 66,
  parameter int PG_W       = 5,
  parameter int COL_W      = 7
) (
  input  logic             clk,
  input  logic             we,
  input  logic             erase,
  input  logic [PG_W-1:0]  wpage,
  input  logic [COL_W-1:0] wcol,
  input  logic [7:0]       wdata,
  input  logic [PG_W-1:0]  rpage,
  input  logic [COL_W-1:0] rcol,
  output logic [7:0]       rdata
);

  localparam int CELLS = NUM_PAGES * PAGE_TOTAL;
  localparam int IDX_W = $clog2(CELLS);

  logic [7:0]       cells [CELLS];
  logic [IDX_W-1:0] widx;
  logic [IDX_W-1:0] ridx;

  // array powers up erased
  initial begin
    for (int i = 0; i < CELLS; i++) cells[i] = 8'hFF;
  end

  assign widx = IDX_W'(cell_index(int'(wpage), int'(wcol), PAGE_TOTAL));
  assign ridx = IDX_W'(cell_index(int'(rpage), int'(rcol), PAGE_TOTAL));

  always_ff @(posedge clk) begin
    if (we) cells[widx] <= merge_cell(cells[widx], wdata, erase);
  end

  always_ff @(posedge clk) begin
    rdata <= cells[ridx];
  end

endmodule

// File: rtl/pe_sequencer.sv
module pe_sequencer
  import nand_pe_pkg::*;
#(
  parameter int NUM_PAGES  = 32,
  parameter int PAGE_TOTAL = 66,
  parameter int BLK_SHIFT  = 4,
  parameter int COL_W      = 7,
  parameter int CNT_W      = 7,
  parameter int PG_W       = 5,
  parameter int ROW_W      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_go,
  input  logic             erase_go,
  input  logic             wp_n,
  input  logic [ROW_W-1:0] row_addr,
  input  logic [COL_W-1:0] col_addr,
  input  logic             preset_wr,
  input  logic [COL_W-1:0] preset_col,
  input  logic [CNT_W-1:0] fill_cnt,
  output logic [CNT_W-1:0] buf_idx,
  output logic             arr_we,
  output logic             arr_erase,
  output logic [PG_W-1:0]  arr_page,
  output logic [COL_W-1:0] arr_col,
  output logic             busy,
  output logic             prog_done,
  output logic             erase_done,
  output logic [COL_W-1:0] preset_q,
  output logic             prog_drop,
  output logic             erase_drop
);

  localparam int TGT_W     = COL_W + 2;
  localparam int BLK_PAGES = 1 << BLK_SHIFT;

  pe_state_e        state_q;
  logic [CNT_W-1:0] cnt_q, len_q;
  logic [TGT_W-1:0] start_q, tgt;
  logic [PG_W-1:0]  page_q, last_q;
  logic [COL_W-1:0] ecol_q;
  logic             idle, row_ok, prog_last;
  int               base_i, last_i;

  assign idle       = (state_q == PE_IDLE);
  assign row_ok     = row_addr < ROW_W'(NUM_PAGES);
  assign prog_drop  = idle && prog_go && (!wp_n || !row_ok);
  assign erase_drop = idle && erase_go && !prog_go && (!wp_n || !row_ok);
  assign tgt        = TGT_W'(target_col(int'(start_q), int'(cnt_q)));
  assign prog_last  = (cnt_q == len_q - CNT_W'(1));

  always_comb begin
    base_i = block_base(int'(row_addr), BLK_SHIFT);
    last_i = base_i + BLK_PAGES - 1;
    if (last_i > NUM_PAGES - 1) last_i = NUM_PAGES - 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= PE_IDLE;
      cnt_q      <= '0;
      len_q      <= '0;
      start_q    <= '0;
      page_q     <= '0;
      last_q     <= '0;
      ecol_q     <= '0;
      preset_q   <= '0;
      prog_done  <= 1'b0;
      erase_done <= 1'b0;
    end else begin
      prog_done  <= 1'b0;
      erase_done <= 1'b0;
      unique case (state_q)
        PE_IDLE: begin
          if (preset_wr) preset_q <= preset_col;
          if (prog_go) begin
            if (prog_drop) begin
              prog_done <= 1'b1;
            end else if (fill_cnt == '0) begin
              prog_done <= 1'b1;
              preset_q  <= '0;
            end else begin
              state_q <= PE_PROG;
              cnt_q   <= '0;
              len_q   <= fill_cnt;
              start_q <= TGT_W'(target_col(int'(col_addr), int'(preset_q)));
              page_q  <= row_addr[PG_W-1:0];
            end
          end else if (erase_go) begin
            if (erase_drop) begin
              erase_done <= 1'b1;
            end else begin
              state_q <= PE_ERASE;
              page_q  <= PG_W'(base_i);
              last_q  <= PG_W'(last_i);
              ecol_q  <= '0;
            end
          end
        end
        PE_PROG: begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (prog_last) begin
            state_q   <= PE_IDLE;
            prog_done <= 1'b1;
            preset_q  <= '0;
          end
        end
        PE_ERASE: begin
          if (ecol_q == COL_W'(PAGE_TOTAL - 1)) begin
            ecol_q <= '0;
            if (page_q == last_q) begin
              state_q    <= PE_IDLE;
              erase_done <= 1'b1;
            end else begin
              page_q <= page_q + PG_W'(1);
            end
          end else begin
            ecol_q <= ecol_q + COL_W'(1);
          end
        end
        default: state_q <= PE_IDLE;
      endcase
    end
  end

  assign busy      = !idle;
  assign buf_idx   = cnt_q;
  assign arr_erase = (state_q == PE_ERASE);
  assign arr_we    = arr_erase || ((state_q == PE_PROG) && (tgt < TGT_W'(PAGE_TOTAL)));
  assign arr_page  = page_q;
  assign arr_col   = arr_erase ? ecol_q : tgt[COL_W-1:0];

endmodule

// File: rtl/nand_pe_engine.sv
module nand_pe_engine
  import nand_pe_pkg::*;
#(
  parameter int  PAGE_BYTES = 64,
  parameter int  NUM_PAGES  = 32,
  parameter int  BLK_SHIFT  = 4,
  localparam int PAGE_TOTAL = PAGE_BYTES + spare_bytes(PAGE_BYTES),
  localparam int COL_W      = $clog2(PAGE_TOTAL),
  localparam int CNT_W      = $clog2(PAGE_TOTAL + 1),
  localparam int PG_W       = $clog2(NUM_PAGES),
  localparam int ROW_W      = PG_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cle,
  input  logic             ale,
  input  logic             wr_en,
  input  logic [7:0]       din,
  input  logic             setup,
  input  logic             preset_wr,
  input  logic [COL_W-1:0] preset_col,
  input  logic [COL_W-1:0] col_addr,
  input  logic [ROW_W-1:0] row_addr,
  input  logic             prog_go,
  input  logic             erase_go,
  input  logic             wp_n,
  input  logic [PG_W-1:0]  rd_page,
  input  logic [COL_W-1:0] rd_col,
  output logic [7:0]       rd_data,
  output logic             busy,
  output logic             prog_done,
  output logic             erase_done
);

  // named internal events, also watched by the checker
  logic             fill_wr;
  logic             setup_eff;
  logic [CNT_W-1:0] fill_level;
  logic [CNT_W-1:0] buf_idx;
  logic [7:0]       buf_byte;
  logic             arr_we, arr_erase;
  logic [PG_W-1:0]  arr_page;
  logic [COL_W-1:0] arr_col;
  logic [COL_W-1:0] preset_level;
  logic             prog_drop, erase_drop;

  assign fill_wr   = wr_en && !cle && !ale && !busy;
  assign setup_eff = setup && !busy;

  pe_page_buffer #(
    .PAGE_TOTAL(PAGE_TOTAL), .COL_W(COL_W), .CNT_W(CNT_W)
  ) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(setup_eff), .wr(fill_wr), .din(din),
    .rd_idx(buf_idx), .rd_byte(buf_byte), .fill_cnt(fill_level)
  );

  pe_sequencer #(
    .NUM_PAGES(NUM_PAGES), .PAGE_TOTAL(PAGE_TOTAL), .BLK_SHIFT(BLK_SHIFT),
    .COL_W(COL_W), .CNT_W(CNT_W), .PG_W(PG_W), .ROW_W(ROW_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .prog_go(prog_go), .erase_go(erase_go), .wp_n(wp_n),
    .row_addr(row_addr), .col_addr(col_addr), .preset_wr(preset_wr),
    .preset_col(preset_col), .fill_cnt(fill_level), .buf_idx(buf_idx),
    .arr_we(arr_we), .arr_erase(arr_erase), .arr_page(arr_page), .arr_col(arr_col),
    .busy(busy), .prog_done(prog_done), .erase_done(erase_done),
    .preset_q(preset_level), .prog_drop(prog_drop), .erase_drop(erase_drop)
  );

  pe_cell_array #(
    .NUM_PAGES(NUM_PAGES), .PAGE_TOTAL(PAGE_TOTAL), .PG_W(PG_W), .COL_W(COL_W)
  ) u_arr (
    .clk(clk), .we(arr_we), .erase(arr_erase), .wpage(arr_page), .wcol(arr_col),
    .wdata(buf_byte), .rpage(rd_page), .rcol(rd_col), .rdata(rd_data)
  );

endmodule

// File: rtl/nand_pe_checker.sv
module nand_pe_checker #(
  parameter int NUM_PAGES  = 32,
  parameter int PAGE_TOTAL = 66,
  parameter int ROW_W      = 6,
  parameter int CNT_W      = 7,
  parameter int COL_W      = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             prog_go,
  input logic             erase_go,
  input logic             wp_n,
  input logic [ROW_W-1:0] row_addr,
  input logic             setup,
  input logic             busy,
  input logic             prog_done,
  input logic             erase_done,
  input logic [CNT_W-1:0] fill_level,
  input logic [COL_W-1:0] preset_level
);

  a_r9_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_done && erase_done));

  a_r9_done_while_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_done || erase_done) |-> !busy);

  a_r9_busy_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(prog_go || erase_go));

  a_r7_wp_prog_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_go && !busy && !wp_n) |=> (prog_done && !busy));

  a_r8_range_erase_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_go && !prog_go && !busy && (int'(row_addr) >= NUM_PAGES)) |=> (erase_done && !busy));

  a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill_level) <= PAGE_TOTAL);

  a_r2_fill_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(fill_level));

  a_r3_setup_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (setup && !busy) |=> (fill_level == '0));

  a_r5_preset_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_done && $past(busy)) |-> (preset_level == '0));

endmodule

bind nand_pe_engine nand_pe_checker #(
  .NUM_PAGES(NUM_PAGES), .PAGE_TOTAL(PAGE_TOTAL), .ROW_W(ROW_W), .CNT_W(CNT_W), .COL_W(COL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .prog_go(prog_go), .erase_go(erase_go), .wp_n(wp_n),
  .row_addr(row_addr), .setup(setup), .busy(busy), .prog_done(prog_done),
  .erase_done(erase_done), .fill_level(fill_level), .preset_level(preset_level)
);

// File: tb/sim_nand_pe_engine.sv
module sim_nand_pe_engine;
  localparam int CLK_PERIOD = 10;
  localparam int PB   = 64;
  localparam int NP   = 8;
  localparam int K    = 2;
  localparam int PT   = PB + PB / 32;
  localparam int CW   = $clog2(PT);
  localparam int PGW  = $clog2(NP);
  localparam int RW   = PGW + 1;

  logic clk = 0, rst_n = 0;
  logic cle = 0, ale = 0, wr_en = 0, setup = 0, preset_wr = 0;
  logic prog_go = 0, erase_go = 0, wp_n = 1;
  logic [7:0] din = 0;
  logic [CW-1:0] preset_col = 0, col_addr = 0, rd_col = 0;
  logic [RW-1:0] row_addr = 0;
  logic [PGW-1:0] rd_page = 0;
  logic [7:0] rd_data;
  logic busy, prog_done, erase_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_pe_engine #(.PAGE_BYTES(PB), .NUM_PAGES(NP), .BLK_SHIFT(K)) u0 (
    .clk(clk), .rst_n(rst_n), .cle(cle), .ale(ale), .wr_en(wr_en), .din(din),
    .setup(setup), .preset_wr(preset_wr), .preset_col(preset_col), .col_addr(col_addr),
    .row_addr(row_addr), .prog_go(prog_go), .erase_go(erase_go), .wp_n(wp_n),
    .rd_page(rd_page), .rd_col(rd_col), .rd_data(rd_data), .busy(busy),
    .prog_done(prog_done), .erase_done(erase_done)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] refm [NP*PT];
  logic [7:0] bbuf [PT];
  int fill_m = 0, preset_m = 0;

  // scoreboard queues
  int qpg[$], qcol[$];
  logic [7:0] qexp[$];
  string qtag[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push_page(input int pg, input string req);
    for (int c = 0; c < PT; c++) begin
      qpg.push_back(pg); qcol.push_back(c); qexp.push_back(refm[pg*PT+c]); qtag.push_back(req);
    end
  endtask

  task automatic drain();
    wait (qpg.size() == 0);
    @(negedge clk);
  endtask

  // monitor: reads each expected cell through the read port (R11)
  initial begin
    forever begin
      wait (qpg.size() != 0);
      rd_page = PGW'(qpg[0]);
      rd_col  = CW'(qcol[0]);
      @(posedge clk);
      @(negedge clk);
      chk(rd_data == qexp[0], qtag[0], int'(rd_data), int'(qexp[0]));
      void'(qpg.pop_front()); void'(qcol.pop_front());
      void'(qexp.pop_front()); void'(qtag.pop_front());
    end
  end

  task automatic fill_bytes(input int n, input logic [7:0] seed, input logic [7:0] step);
    setup = 1; @(negedge clk); setup = 0;
    fill_m = 0;
    for (int i = 0; i < n; i++) begin
      wr_en = 1; din = seed + 8'(i) * step;
      if (fill_m < PT) begin bbuf[fill_m] = din; fill_m++; end
      @(negedge clk);
    end
    wr_en = 0;
  endtask

  task automatic model_prog(input int row, input int col);
    for (int i = 0; i < fill_m; i++) begin
      int p = col + preset_m + i;
      if (p < PT) refm[row*PT+p] = refm[row*PT+p] & bbuf[i];
    end
    preset_m = 0;
  endtask

  task automatic model_erase(input int row);
    int b = (row >> K) << K;
    for (int pg = b; pg < b + (1 << K); pg++)
      for (int c = 0; c < PT; c++) refm[pg*PT+c] = 8'hFF;
  endtask

  task automatic run_op(input bit is_prog, input int row, input int col, input bit wp,
                        input string req);
    bit ok = wp && (row < NP);
    int len, cyc;
    if (is_prog) begin
      len = ok ? fill_m : 0;
      if (ok) model_prog(row, col);
    end else begin
      len = ok ? (1 << K) * PT : 0;
      if (ok) model_erase(row);
    end
    row_addr = RW'(row); col_addr = CW'(col); wp_n = wp;
    if (is_prog) prog_go = 1; else erase_go = 1;
    @(negedge clk);
    prog_go = 0; erase_go = 0;
    cyc = 0;
    while (busy && cyc < 5000) begin cyc++; @(negedge clk); end
    chk(cyc == len, {req, " R9 busy length"}, cyc, len);
    chk((is_prog ? prog_done : erase_done) == 1'b1, {req, " R9 done pulse"}, 0, 1);
    @(negedge clk);
    chk(!prog_done && !erase_done, {req, " R9 single pulse"}, int'(prog_done | erase_done), 0);
    wp_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    for (int i = 0; i < NP*PT; i++) refm[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !prog_done && !erase_done, "R1 outputs idle", int'(busy), 0);
    push_page(0, "R1 R11 erased"); push_page(NP-1, "R1 R11 erased"); drain();

    // R4 basic program and repeated AND
    fill_bytes(10, 8'hF0, 8'h11);
    run_op(1, 1, 5, 1, "R4 prog");
    push_page(1, "R4 merge"); drain();
    fill_bytes(4, 8'h0F, 8'h00);
    run_op(1, 1, 5, 1, "R4 and");
    push_page(1, "R4 and merge"); drain();
    fill_bytes(3, 8'h3C, 8'h01);
    run_op(1, 5, 0, 1, "R4 prog p5");

    // R4 clip at page end with preset, then R5 preset cleared
    preset_col = CW'(60); preset_wr = 1; @(negedge clk); preset_wr = 0; preset_m = 60;
    fill_bytes(10, 8'h00, 8'h00);
    run_op(1, 2, 0, 1, "R4 clip");
    fill_bytes(2, 8'h00, 8'h00);
    run_op(1, 2, 10, 1, "R5 preset zero");
    push_page(2, "R4 R5 page2"); drain();

    // R2 overflow fill with cle/ale blocked bytes
    setup = 1; @(negedge clk); setup = 0; fill_m = 0;
    cle = 1; wr_en = 1; din = 8'h00; @(negedge clk); cle = 0;
    ale = 1; @(negedge clk); ale = 0;
    for (int i = 0; i < PT + 4; i++) begin
      din = 8'(i) & 8'h0F;
      if (fill_m < PT) begin bbuf[fill_m] = din; fill_m++; end
      @(negedge clk);
    end
    wr_en = 0;
    run_op(1, 3, 0, 1, "R2 full buffer");
    push_page(3, "R2 page3"); drain();

    // R3 setup empties buffer
    fill_bytes(5, 8'h00, 8'h00);
    setup = 1; @(negedge clk); setup = 0; fill_m = 0;
    run_op(1, 4, 0, 1, "R3 empty prog");
    push_page(4, "R3 page4"); drain();

    // R7 write protect
    fill_bytes(3, 8'h00, 8'h00);
    run_op(1, 6, 0, 0, "R7 prog wp");
    run_op(0, 3, 0, 0, "R7 erase wp");
    push_page(6, "R7 page6"); push_page(3, "R7 page3"); drain();

    // R8 out of range
    run_op(1, 9, 0, 1, "R8 prog range");
    run_op(0, 12, 0, 1, "R8 erase range");

    // R6 block erase aligned down
    run_op(0, 2, 0, 1, "R6 erase");
    for (int pg = 0; pg < NP; pg++) push_page(pg, "R6 block");
    drain();

    // R10 strobes while busy ignored, R2 fill blocked while busy
    fill_bytes(20, 8'h00, 8'h00);
    model_prog(6, 0);
    row_addr = RW'(6); col_addr = '0; prog_go = 1; @(negedge clk); prog_go = 0;
    @(negedge clk);
    row_addr = RW'(5); erase_go = 1; wr_en = 1; din = 8'hAA; @(negedge clk);
    erase_go = 0;
    repeat (4) @(negedge clk);
    wr_en = 0;
    cyc = 0;
    while (busy && cyc < 5000) begin cyc++; @(negedge clk); end
    chk(!erase_done, "R10 no erase done", int'(erase_done), 0);
    push_page(5, "R10 page5 kept"); push_page(6, "R10 page6"); drain();
    run_op(1, 7, 0, 1, "R2 fill kept 20");
    push_page(7, "R2 page7"); drain();

    // R10 simultaneous strobes: program wins
    fill_bytes(1, 8'h00, 8'h00);
    model_prog(4, 3);
    row_addr = RW'(4); col_addr = CW'(3); prog_go = 1; erase_go = 1;
    @(negedge clk); prog_go = 0; erase_go = 0;
    chk(busy == 1'b1, "R10 prog taken", int'(busy), 1);
    @(negedge clk);
    chk(prog_done && !erase_done, "R10 prog wins", int'({prog_done, erase_done}), 2);
    push_page(4, "R10 page4"); push_page(5, "R10 page5"); drain();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule